// File: doc/BRIEF.md
# Row-Granular Firmware Upload Buffer

This block sits between the path that delivers a new firmware image from the host and the sequencer that writes that image into configuration memory one row at a time. The host side writes 16-bit words. The sequencer side only ever sees complete 256-bit rows. A row becomes visible to the reader only when all sixteen of its words have arrived. While a row is still being filled, it counts for nothing: it is not counted as available, it does not move the level flags, and it does not count toward full.

The two sides run at different rates. Each side has a threshold flag so it can pace itself without watching the other. The writer sees a partial-full flag and the reader sees a partial-empty flag. Both thresholds are set as row counts. A row is popped in a single cycle. The head row is presented in show-ahead fashion, so the data is valid whenever a row is available.

Top module: `fwb_row_fifo`

## Requirements
- R1: After reset, `rd_avail`, `wr_full`, `wr_pfull` and `wr_overflow` are 0 and `rd_pempty` is 1.
- R2: `rd_avail` rises only on the clock edge that accepts the 16th word of a row. After 15 words of a row it stays 0.
- R3: In a row, the first word written occupies `rd_row[255:240]` and the 16th word occupies `rd_row[15:0]`. Each word fills the next lower 16-bit lane.
- R4: Complete rows are presented on `rd_row` in the order they were completed. A row pop (`rd_en` while `rd_avail`) advances to the next row on the next edge.
- R5: `rd_en` while `rd_avail` is 0 has no effect. No row is lost and no phantom row appears.
- R6: `wr_full` is 1 exactly when `DEPTH_ROWS` complete rows are stored. Words written while full are discarded and leave both the stored rows and the next row being assembled untouched.
- R7: `wr_overflow` is set by any write while `wr_full` is 1 and stays set until reset.
- R8: `wr_pfull` is 1 when at least `PF_ROWS` complete rows are stored.
- R9: `rd_pempty` is 1 when at most `PE_ROWS` complete rows are stored.
- R10: A pop and a row completion in the same cycle leave the stored row count unchanged and keep row order.
- R11: Words of an incomplete row do not count toward `wr_full`, `wr_pfull` or `rd_pempty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one word |
| wr_word | input | 16 | Word to write |
| wr_full | output | 1 | All row slots hold complete rows |
| wr_pfull | output | 1 | Stored rows at or above the partial-full threshold |
| wr_overflow | output | 1 | Sticky: a write arrived while full |
| rd_en | input | 1 | Pop the head row |
| rd_row | output | 256 | Head row, first word in the top lane |
| rd_avail | output | 1 | At least one complete row stored |
| rd_pempty | output | 1 | Stored rows at or below the partial-empty threshold |

## Verification
Rows are built from words that encode both a row tag and the word index. A 15-word prefix followed by the 16th word separates "visible on completion" from "visible early". Wrong lane order or wrong row order shows up as a tag or index mismatch. Filling the store row by row walks both thresholds and full up through each count. Extra words written while full, followed by draining and a fresh row, show whether discarded words leaked into memory or into the assembly register. Reads when empty, and a pop coinciding with a row completion, separate correct count handling from off-by-one counting.

// File: rtl/fwb_pkg.sv
// Shared defaults and the level-flag bundle for the firmware row buffer.
package fwb_pkg;
    localparam int DEF_WORD_W    = 16;
    localparam int DEF_ROW_WORDS = 16;
    localparam int DEF_DEPTH     = 1024;

    typedef struct packed {
        logic full;
        logic avail;
        logic pfull;
        logic pempty;
    } level_t;
endpackage

// File: rtl/fwb_row_assembler.sv
// Collects words into a row shift register and emits a commit pulse with the
// finished row when the last word is accepted. Assumes ROW_WORDS >= 2.
// A blocked word (store full) is neither shifted in nor counted.
module fwb_row_assembler #(
    parameter int WORD_W    = 16,
    parameter int ROW_WORDS = 16,
    localparam int ROW_W    = WORD_W * ROW_WORDS,
    localparam int FILL_W   = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              blocked,
    output logic              commit,
    output logic [ROW_W-1:0]  row_out
);
    logic [FILL_W-1:0] fill;
    logic [ROW_W-1:0]  shreg;
    logic              accept;
    logic              last;

    // Accept decision and the row as it looks with the incoming word added.
    always_comb begin
        accept  = wr_en && !blocked;
        last    = (fill == FILL_W'(ROW_WORDS - 1));
        commit  = accept && last;
        row_out = {shreg[ROW_W-WORD_W-1:0], wr_word};
    end

    // Shift accepted words in and track how many the open row holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill  <= '0;
            shreg <= '0;
        end else if (accept) begin
            shreg <= row_out;
            fill  <= last ? '0 : fill + 1'b1;
        end
    end
endmodule

// File: rtl/fwb_row_store.sv
// Circular store of complete rows with a stored-row count. The head row is
// shown combinationally. Pops with nothing stored are ignored. The caller
// never pushes while the store is full.
module fwb_row_store #(
    parameter int ROW_W = 256,
    parameter int DEPTH = 1024,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ROW_W-1:0] push_row,
    input  logic             pop_req,
    output logic [CNT_W-1:0] count,
    output logic [ROW_W-1:0] head_row
);
    logic [ROW_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             pop;

    // Effective pop and head-row view.
    always_comb begin
        pop      = pop_req && (count != '0);
        head_row = mem[rptr];
    end

    // Row storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_row;
    end

    // Pointer and count upkeep, with explicit wrap for any depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fwb_level_flags.sv
// Derives full, available and both threshold flags from the stored-row count.
// Assumes PF_ROWS <= DEPTH and PE_ROWS < DEPTH.
module fwb_level_flags
    import fwb_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int PF_ROWS = 768,
    parameter int PE_ROWS = 256,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    output level_t           lvl
);
    // Compare the committed-row count against each limit.
    always_comb begin
        lvl.full   = (count == CNT_W'(DEPTH));
        lvl.avail  = (count != '0);
        lvl.pfull  = (count >= CNT_W'(PF_ROWS));
        lvl.pempty = (count <= CNT_W'(PE_ROWS));
    end
endmodule

// File: rtl/fwb_row_fifo.sv
// Firmware upload buffer: 16-bit words in, whole rows out. Only complete rows
// are stored or counted. Writes while full are dropped and flagged stickily.
module fwb_row_fifo
    import fwb_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int ROW_WORDS  = DEF_ROW_WORDS,
    parameter int DEPTH_ROWS = DEF_DEPTH,
    parameter int PF_ROWS    = 768,
    parameter int PE_ROWS    = 256,
    localparam int ROW_W     = WORD_W * ROW_WORDS,
    localparam int CNT_W     = $clog2(DEPTH_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic              wr_full,
    output logic              wr_pfull,
    output logic              wr_overflow,
    input  logic              rd_en,
    output logic [ROW_W-1:0]  rd_row,
    output logic              rd_avail,
    output logic              rd_pempty
);
    logic             commit;
    logic [ROW_W-1:0] new_row;
    logic [CNT_W-1:0] count;
    level_t           lvl;

    fwb_row_assembler #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_asm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .blocked(lvl.full), .commit(commit), .row_out(new_row)
    );

    fwb_row_store #(.ROW_W(ROW_W), .DEPTH(DEPTH_ROWS)) u_store (
        .clk(clk), .rst_n(rst_n), .push(commit), .push_row(new_row),
        .pop_req(rd_en), .count(count), .head_row(rd_row)
    );

    fwb_level_flags #(.DEPTH(DEPTH_ROWS), .PF_ROWS(PF_ROWS), .PE_ROWS(PE_ROWS)) u_flags (
        .count(count), .lvl(lvl)
    );

    // Sticky record of any write attempted while full.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wr_overflow <= 1'b0;
        else if (wr_en && lvl.full)  wr_overflow <= 1'b1;
    end

    // Flag fan-out to the ports.
    always_comb begin
        wr_full   = lvl.full;
        wr_pfull  = lvl.pfull;
        rd_avail  = lvl.avail;
        rd_pempty = lvl.pempty;
    end
endmodule

// File: rtl/fwb_row_fifo_chk.sv
// Port-level properties of the row buffer, bound into every instance.
module fwb_row_fifo_chk #(
    parameter int ROW_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             wr_full,
    input logic             wr_pfull,
    input logic             wr_overflow,
    input logic             rd_avail,
    input logic             rd_pempty,
    input logic [ROW_W-1:0] rd_row
);
    a_r2_avail_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_avail) |-> $past(wr_en));

    a_r4_head_held_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_avail && !rd_en) |=> $stable(rd_row));

    a_r5_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_avail && rd_en && !wr_en) |=> !rd_avail);

    a_r6_full_has_rows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> (rd_avail && !rd_pempty));

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overflow |=> wr_overflow);

    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_overflow) |-> $past(wr_en && wr_full));

    a_r8_full_implies_pfull: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> wr_pfull);

    a_r9_empty_is_pempty: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_avail |-> rd_pempty);
endmodule

bind fwb_row_fifo fwb_row_fifo_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wr_full(wr_full), .wr_pfull(wr_pfull), .wr_overflow(wr_overflow),
    .rd_avail(rd_avail), .rd_pempty(rd_pempty), .rd_row(rd_row)
);

// File: tb/tb_fwb_row_fifo.sv
module tb_fwb_row_fifo;
    localparam int DEPTH = 4;
    localparam int PF    = 3;
    localparam int PE    = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [15:0]  wr_word = '0;
    logic         rd_en = 1'b0;
    logic         wr_full, wr_pfull, wr_overflow, rd_avail, rd_pempty;
    logic [255:0] rd_row;
    int checks = 0;
    int errors = 0;

    fwb_row_fifo #(.DEPTH_ROWS(DEPTH), .PF_ROWS(PF), .PE_ROWS(PE)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_full(wr_full), .wr_pfull(wr_pfull), .wr_overflow(wr_overflow),
        .rd_en(rd_en), .rd_row(rd_row), .rd_avail(rd_avail), .rd_pempty(rd_pempty)
    );

    always #4 clk = ~clk;

    function automatic logic [255:0] exp_row(input logic [7:0] tag);
        logic [255:0] r;
        for (int i = 0; i < 16; i++) r[255-16*i -: 16] = {tag, 8'(i)};
        return r;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic av, input logic fu,
                             input logic pf, input logic pe);
        chk(req, {252'd0, rd_avail, wr_full, wr_pfull, rd_pempty},
                 {252'd0, av, fu, pf, pe});
    endtask

    // Write words idx_lo..idx_hi of a tagged row, one per cycle.
    task automatic put_words(input logic [7:0] tag, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) begin
            @(negedge clk); wr_en = 1'b1; wr_word = {tag, 8'(i)};
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pop_row();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_flags("R1 flags", 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 overflow", {255'd0, wr_overflow}, 256'd0);
    endtask

    task automatic t_partial_row();
        put_words(8'h01, 0, 14);
        chk_flags("R2 R11 after 15 words", 1'b0, 1'b0, 1'b0, 1'b1);
        put_words(8'h01, 15, 15);
        chk_flags("R2 after 16th word", 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R3 packing", rd_row, exp_row(8'h01));
        chk("R3 first word top lane", {240'd0, rd_row[255:240]}, 256'h0100);
    endtask

    task automatic t_order();
        put_words(8'h02, 0, 15);
        chk("R4 head still first", rd_row, exp_row(8'h01));
        pop_row();
        chk("R4 second row next", rd_row, exp_row(8'h02));
        pop_row();
        chk_flags("R4 drained", 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_empty_read();
        pop_row();
        pop_row();
        chk_flags("R5 empty read", 1'b0, 1'b0, 1'b0, 1'b1);
        put_words(8'h03, 0, 15);
        chk("R5 row after empty read", rd_row, exp_row(8'h03));
        pop_row();
        chk_flags("R5 single row only", 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_levels();
        put_words(8'h10, 0, 15);
        chk_flags("R9 one row", 1'b1, 1'b0, 1'b0, 1'b1);
        put_words(8'h11, 0, 15);
        chk_flags("R9 two rows", 1'b1, 1'b0, 1'b0, 1'b0);
        put_words(8'h12, 0, 15);
        chk_flags("R8 three rows", 1'b1, 1'b0, 1'b1, 1'b0);
        put_words(8'h13, 0, 15);
        chk_flags("R6 four rows", 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_full_drop();
        put_words(8'hEE, 0, 2);
        chk("R7 overflow set", {255'd0, wr_overflow}, {255'd0, 1'b1});
        chk("R6 head kept", rd_row, exp_row(8'h10));
        pop_row();
        chk_flags("R6 one freed", 1'b1, 1'b0, 1'b1, 1'b0);
        put_words(8'h14, 0, 15);
        chk_flags("R6 full again", 1'b1, 1'b1, 1'b1, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            chk("R6 contents after drop", rd_row, exp_row(8'(8'h10 + k)));
            pop_row();
        end
        chk_flags("R6 drained", 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 overflow persists", {255'd0, wr_overflow}, {255'd0, 1'b1});
    endtask

    task automatic t_simultaneous();
        put_words(8'h20, 0, 15);
        put_words(8'h21, 0, 14);
        @(negedge clk); wr_en = 1'b1; wr_word = {8'h21, 8'd15}; rd_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        chk_flags("R10 count held", 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R10 order", rd_row, exp_row(8'h21));
        pop_row();
        chk_flags("R10 drained", 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset_clears();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R7 cleared by reset", {255'd0, wr_overflow}, 256'd0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_partial_row();
        t_order();
        t_empty_read();
        t_levels();
        t_full_drop();
        t_simultaneous();
        t_reset_clears();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule